// File: doc/BRIEF.md
# Parity-Checked Status Character Store

This block receives 8-bit character bytes from a broadcast data slicer. Bit 7 of each byte carries odd parity over the whole byte. Each byte that passes the check is written, with bit 7 cleared, into a 20-entry status-message store. A host reads that store through a register window at addresses 0x1E to 0x31.

A start-of-message pulse arms the writer and points it at the first slot. Each byte that arrives after that takes the next slot, whether or not it was written, so a corrupted character leaves a gap rather than shifting the rest of the message. A saturating counter records parity failures. A separate input clears the counter.

The writer is a three-state machine:
- `ST_IDLE` is the state after reset, where no message is armed. The transition `arm` moves it to `ST_FILL` on `msg_start`.
- `ST_FILL` places bytes into the store. The transition `rearm` stays in `ST_FILL` on `msg_start` and returns the pointer to slot 0. The transition `advance` stays in `ST_FILL` on a byte while the pointer is below the last slot. The transition `finish` moves to `ST_DONE` on the byte that lands in the last slot.
- `ST_DONE` ignores bytes. The transition `arm` moves it back to `ST_FILL` on `msg_start`.

Top module: `char_store_writer`

## Requirements
- R1: A byte is valid when the number of ones across all 8 bits is odd. A byte with an even count, including 0x00, is a parity error.
- R2: A byte with a parity error is not written. The slot it would have occupied keeps its previous contents.
- R3: A valid byte is stored with bit 7 forced to 0 and bits 6:0 unchanged.
- R4: `msg_start` points the writer at slot 0 (host address 0x1E). Each byte accepted while filling advances the pointer by one, whether or not it was written. A byte presented in the same cycle as `msg_start` is discarded.
- R5: Bytes that arrive before the first `msg_start` after reset are ignored. Bytes that arrive after the byte for slot 19 (0x31) are also ignored until the next `msg_start`. Ignored bytes are neither written nor counted.
- R6: `err_count` increases by one for each parity error on a byte accepted while filling. It saturates at 255. `err_clr` sets it to 0 and takes priority over a simultaneous error.
- R7: `rd_data` returns, one cycle after `rd_addr` is applied, the stored byte for addresses 0x1E to 0x31, and 0x00 for any other address. A read and a write to the same slot in the same cycle return the old contents.
- R8: A synchronous reset fills every slot with 0x20, zeroes `err_count` and `rd_data`, and leaves the writer in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Character byte with odd parity in bit 7 |
| rx_valid | input | 1 | `rx_byte` is present this cycle |
| msg_start | input | 1 | Start of a new status message |
| err_clr | input | 1 | Clears the parity error counter |
| rd_addr | input | 8 | Host register address |
| rd_data | output | 8 | Read data, registered |
| err_count | output | 8 | Saturating parity error count |

## Verification
A wrong pointer or wrong state shows up as a character in the wrong slot, or as a byte written while the writer should be idle or done. Such a fault becomes visible at `rd_data` on the next host read of the affected slot, one cycle after the address is applied. A wrong parity decision shows up in two places: `err_count` is wrong on the cycle after the byte, and the slot reads back wrong once it is read. The bench compares every cycle's read data and count against a model. Each fault therefore appears within a cycle of the first read or count that exposes it.

// File: rtl/csw_pkg.sv
package csw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } fill_state_e;
endpackage

// File: rtl/csw_parity.sv
module csw_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd_ok,
    output logic [W-1:0] stripped
);
    always_comb begin
        odd_ok   = ^din;
        stripped = {1'b0, din[W-2:0]};
    end
endmodule

// File: rtl/csw_err_cnt.sv
module csw_err_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         bump,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (bump && cnt != MAX)
            cnt <= cnt + W'(1);
    end

    // R6: a clear always lands on zero
    assert_clr_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R6: saturation holds
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAX && !clr) |=> cnt == MAX);
    // R6: counting step is one
    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (bump && !clr && cnt != MAX) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/csw_store.sv
module csw_store #(
    parameter int          DEPTH    = 20,
    parameter int          DW       = 8,
    parameter int          AW       = 8,
    parameter logic [7:0]  BASE     = 8'h1E,
    parameter logic [7:0]  FILL_VAL = 8'h20,
    localparam int         IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);
    localparam logic [AW-1:0] LO = AW'(BASE);
    localparam logic [AW-1:0] HI = AW'(BASE) + AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic          in_win;
    logic [AW-1:0] rd_off;

    always_comb begin
        in_win = (rd_addr >= LO) && (rd_addr <= HI);
        rd_off = rd_addr - LO;
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[gi] <= DW'(FILL_VAL);
                else if (we && widx == IDX_W'(gi))
                    mem[gi] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (in_win)
            rd_data <= mem[rd_off[IDX_W-1:0]];
        else
            rd_data <= '0;
    end

    // R3: nothing written ever carries a set top bit
    assert_msb_zero_R3: assert property (@(posedge clk) disable iff (rst)
        we |-> !wdata[DW-1]);
    // R7: outside the window reads zero one cycle later
    assert_oow_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> rd_data == '0);
endmodule

// File: rtl/char_store_writer.sv
module char_store_writer
    import csw_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         AW       = 8,
    parameter int         CNT_W    = 8,
    parameter logic [7:0] WIN_BASE = 8'h1E,
    parameter logic [7:0] WIN_LAST = 8'h31,
    parameter logic [7:0] FILL_VAL = 8'h20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rx_valid,
    input  logic             msg_start,
    input  logic             err_clr,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] err_count
);
    localparam int               DEPTH    = int'(WIN_LAST) - int'(WIN_BASE) + 1;
    localparam int               IDX_W    = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    fill_state_e      state, nxt_state;
    logic [IDX_W-1:0] ptr, nxt_ptr;
    logic             par_ok;
    logic [DW-1:0]    clean;
    logic             wr_en, err_bump;

    csw_parity #(.W(DW)) u_par (
        .din      (rx_byte),
        .odd_ok   (par_ok),
        .stripped (clean)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            state <= nxt_state;
            ptr   <= nxt_ptr;
        end
    end

    // next state and outputs
    always_comb begin
        nxt_state = state;
        nxt_ptr   = ptr;
        wr_en     = 1'b0;
        err_bump  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (msg_start) begin
                    nxt_state = ST_FILL;
                    nxt_ptr   = '0;
                end
            end
            ST_FILL: begin
                if (msg_start) begin
                    nxt_ptr = '0;
                end else if (rx_valid) begin
                    wr_en    = par_ok;
                    err_bump = !par_ok;
                    if (ptr == LAST_IDX)
                        nxt_state = ST_DONE;
                    else
                        nxt_ptr = ptr + IDX_W'(1);
                end
            end
            ST_DONE: begin
                if (msg_start) begin
                    nxt_state = ST_FILL;
                    nxt_ptr   = '0;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    csw_store #(
        .DEPTH    (DEPTH),
        .DW       (DW),
        .AW       (AW),
        .BASE     (WIN_BASE),
        .FILL_VAL (FILL_VAL)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .widx    (ptr),
        .wdata   (clean),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    csw_err_cnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (err_clr),
        .bump (err_bump),
        .cnt  (err_count)
    );

    // R4: a start lands on slot 0 in the filling state
    assert_start_slot0_R4: assert property (@(posedge clk) disable iff (rst)
        msg_start |=> (state == ST_FILL && ptr == '0));
    // R4: each accepted byte moves the pointer by one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && rx_valid && !msg_start && ptr != LAST_IDX)
        |=> ptr == $past(ptr) + IDX_W'(1));
    // R5: done stays done until a new start
    assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !msg_start) |=> state == ST_DONE);
    // R5: idle stays idle until a start
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !msg_start) |=> state == ST_IDLE);
endmodule

// File: tb/sim_char_store_writer.sv
module sim_char_store_writer;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_byte;
    logic       rx_valid, msg_start, err_clr;
    logic [7:0] rd_addr;
    logic [7:0] rd_data, err_count;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_mem [20];
    int         m_ptr;   // -1 idle, 0..19 filling, 20 done
    int         m_cnt;

    always #4 clk = ~clk;

    char_store_writer u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .msg_start(msg_start), .err_clr(err_clr), .rd_addr(rd_addr),
        .rd_data(rd_data), .err_count(err_count)
    );

    function automatic logic [7:0] mk_byte(logic [6:0] d, bit good);
        logic p;
        p = ^d;
        return {good ? ~p : p, d};
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a >= 8'h1E && a <= 8'h31) return m_mem[a - 8'h1E];
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle: drive, update model, check read data and count
    task automatic cyc(bit v, logic [7:0] b, bit s, bit c, logic [7:0] a,
                       string tag);
        logic [7:0] er;
        @(negedge clk);
        rx_valid = v; rx_byte = b; msg_start = s; err_clr = c; rd_addr = a;
        er = exp_read(a);             // R7: read returns pre-write contents
        if (s) m_ptr = 0;
        else if (v && m_ptr >= 0 && m_ptr < 20) begin
            if (^b) m_mem[m_ptr] = {1'b0, b[6:0]};
            else if (!c && m_cnt < 255) m_cnt++;
            m_ptr++;
        end
        if (c) m_cnt = 0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " rd"}, rd_data, er);
        check({tag, " cnt"}, err_count, 8'(m_cnt));
        rx_valid = 0; msg_start = 0; err_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        rx_byte = 0; rx_valid = 0; msg_start = 0; err_clr = 0; rd_addr = 0;
        rst = 1;
        for (int i = 0; i < 20; i++) m_mem[i] = 8'h20;
        m_ptr = -1; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check("R8 cnt", err_count, 8'h00);
        // R8: reset fill
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 8'(8'h1E + i), "R8");
        // R7: outside window
        cyc(0, 0, 0, 0, 8'h1D, "R7");
        cyc(0, 0, 0, 0, 8'h32, "R7");
        cyc(0, 0, 0, 0, 8'hFF, "R7");
        // R5: idle ignores good and bad bytes
        cyc(1, mk_byte(7'h41, 1), 0, 0, 8'h1E, "R5");
        cyc(1, mk_byte(7'h41, 0), 0, 0, 8'h1E, "R5");
        cyc(0, 0, 0, 0, 8'h1E, "R5");
        // R4: byte alongside start discarded
        cyc(1, mk_byte(7'h55, 1), 1, 0, 8'h1E, "R4");
        cyc(0, 0, 0, 0, 8'h1E, "R4");
        // R1/R3: good byte with top bit set stored with top bit clear
        cyc(1, 8'hC1, 0, 0, 8'h1E, "R3");
        cyc(0, 0, 0, 0, 8'h1E, "R3");
        // R2: bad byte keeps slot, R6 counts
        cyc(1, 8'h41, 0, 0, 8'h1F, "R2");
        cyc(0, 0, 0, 0, 8'h1F, "R2");
        // R1: zero byte is an error, 0x80 is good and stores 0x00
        cyc(1, 8'h00, 0, 0, 8'h20, "R1");
        cyc(1, 8'h80, 0, 0, 8'h20, "R1");
        cyc(0, 0, 0, 0, 8'h21, "R1");
        // R7: read and write the same slot together
        cyc(1, mk_byte(7'h33, 1), 0, 0, 8'h22, "R7");
        cyc(0, 0, 0, 0, 8'h22, "R7");
        // R5: fill to the end, then overflow bytes ignored
        for (int i = 0; i < 15; i++)
            cyc(1, mk_byte(7'(8'h60 + i), 1), 0, 0, 8'h31, "R4");
        cyc(1, mk_byte(7'h7E, 1), 0, 0, 8'h31, "R5");
        cyc(1, mk_byte(7'h7E, 0), 0, 0, 8'h31, "R5");
        cyc(0, 0, 0, 0, 8'h31, "R5");
        // R6: clear
        cyc(0, 0, 0, 1, 8'h00, "R6");
        // random messages
        for (int m = 0; m < 6; m++) begin
            cyc(0, 0, 1, 0, 8'h1E, "R4");
            for (int i = 0; i < 26; i++) begin
                cyc(($urandom % 5) != 0, mk_byte(7'($urandom), ($urandom % 3) != 0),
                    0, ($urandom % 40) == 0, 8'(8'h1C + ($urandom % 24)), "R2");
            end
            for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 8'(8'h1E + i), "R3");
        end
        // R6: saturation with all-bad messages
        for (int m = 0; m < 14; m++) begin
            cyc(0, 0, 1, 0, 8'h00, "R6");
            for (int i = 0; i < 20; i++)
                cyc(1, mk_byte(7'($urandom), 0), 0, 0, 8'h00, "R6");
        end
        check("R6 sat", err_count, 8'hFF);
        // R6: clear wins over simultaneous error
        cyc(0, 0, 1, 0, 8'h00, "R6");
        cyc(1, mk_byte(7'h11, 0), 0, 1, 8'h00, "R6");
        cyc(1, mk_byte(7'h11, 0), 0, 0, 8'h00, "R6");
        // R8: reset mid-message restores fill and idle
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 20; i++) m_mem[i] = 8'h20;
        m_ptr = -1; m_cnt = 0;
        cyc(1, mk_byte(7'h44, 1), 0, 0, 8'h1E, "R8");
        cyc(0, 0, 0, 0, 8'h1E, "R8");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule